// File: doc/BRIEF.md
# PWM Bank Shared Enable and Wrap-Interrupt Control

This block is the common control unit for a bank of PWM slices (12 by default). It holds a vector that enables the slices, with one bit for each slice. It also collects the wrap event that each slice raises once per period and turns those events into two interrupt request lines. Software reaches it over a simple single-cycle register bus. Reads are combinational on the address, and writes take effect at the clock edge.

Each slice has a raw pending bit. A wrap pulse sets the bit, and writing a 1 to it clears it. Each interrupt line has its own enable mask, its own force vector and a read-only status view. The status of a line is the pending bits under that line's mask, merged with that line's force bits. The line raises its request whenever any status bit is set.

Two address bits pick the kind of write access. A plain access loads the register. The set alias ORs the written ones into the register, and the clear alias removes them. With the aliases, software can change a single bit and never reads the register first.

Top module: `pwm_ctl_top`

## Requirements
- R1: After a synchronous reset, every register is zero. `slice_en` and `irq` are then 0, and every mapped offset reads 0.
- R2: A plain write (address bits [13:12] equal to 00 or 01) to offset 0x0F0 loads `bus_wdata[11:0]` into the slice enable vector. From the next cycle the vector drives `slice_en` and reads back at 0x0F0.
- R3: A write with address bits [13:12] = 10 (set alias, +0x2000) ORs the written ones into the addressed slice-enable, line-enable or line-force register. A write with bits [13:12] = 11 (clear alias, +0x3000) clears the written ones. All other bits keep their value.
- R4: A 1 on `wrap_pulse[i]` sets raw pending bit i (offset 0x0F4) in the next cycle. The bit holds until software clears it.
- R5: A plain write or a clear-alias write to 0x0F4 clears each pending bit written as 1. Bits written as 0 do not change. A set-alias write to 0x0F4 has no effect.
- R6: If a wrap pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: Line k (k = 0, 1) has its enable mask at 0x0F8 + 0xC·k, its force vector at 0x0FC + 0xC·k and its status at 0x100 + 0xC·k. The status reads as (pending AND enable_k) OR force_k.
- R8: `irq[k]` is high exactly when the status of line k is non-zero. A change that a register write causes shows on the line in the cycle after the write edge.
- R9: Writes of any access kind to a status offset do not change any register.
- R10: Bits 31:12 of `bus_rdata` always read 0, and the same bits of write data are ignored. An unmapped offset, or an address with bits [15:14] not zero, reads 0 and writes nothing. Reads return the register whatever bits [13:12] hold.
- R11: The two lines are independent. The mask and force of one line have no effect on the other line's status or request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address: [11:0] offset, [13:12] access kind, [15:14] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wrap_pulse | input | 12 | One-cycle wrap event from each slice |
| slice_en | output | 12 | Enable vector to the slices |
| irq | output | 2 | Interrupt request lines |

## Verification
A slice's wrap pulse and a software write that clears the same pending bit can land in one cycle. The bench provokes this in two ways. In a directed step it drives a wrap on a bit while a plain write and a clear-alias write try to clear that bit. In the random phase it drives wrap vectors together with writes of random kind to the pending register. A model in the bench applies the clear first and the wrap second. After every step the bench compares the model with the pending readback and with both request lines, so any step where the clear beats the wrap shows as a mismatch.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;

    localparam int BUS_DATA_W = 32;
    localparam int BUS_ADDR_W = 16;
    localparam int OFF_W      = 12;

    // Access kind carried in address bits [13:12]
    typedef enum logic [1:0] {
        ACC_PLAIN     = 2'b00,
        ACC_PLAIN_ALT = 2'b01,
        ACC_SET       = 2'b10,
        ACC_CLR       = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic set_bits;
        logic clr_bits;
    } wr_op_t;

    localparam logic [OFF_W-1:0] OFF_SLICE_EN   = 12'h0F0;
    localparam logic [OFF_W-1:0] OFF_PEND       = 12'h0F4;
    localparam logic [OFF_W-1:0] OFF_LINE0      = 12'h0F8;
    localparam logic [OFF_W-1:0] LINE_STRIDE    = 12'h00C;
    localparam logic [OFF_W-1:0] LINE_MASK_OFS  = 12'h000;
    localparam logic [OFF_W-1:0] LINE_FORCE_OFS = 12'h004;
    localparam logic [OFF_W-1:0] LINE_STAT_OFS  = 12'h008;

    function automatic wr_op_t kind_to_op(acc_kind_e k);
        wr_op_t op;
        op.set_bits = (k == ACC_SET);
        op.clr_bits = (k == ACC_CLR);
        return op;
    endfunction

    function automatic logic [OFF_W-1:0] line_reg_off(int unsigned k, logic [OFF_W-1:0] rel);
        return OFF_LINE0 + OFF_W'(k) * LINE_STRIDE + rel;
    endfunction

endpackage

// File: rtl/pwm_ctl_decode.sv
module pwm_ctl_decode
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_LINES = 2
) (
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    output wr_op_t                op,
    output logic                  hit_slice_en,
    output logic                  hit_pend,
    output logic [NUM_LINES-1:0]  hit_mask,
    output logic [NUM_LINES-1:0]  hit_force,
    output logic [NUM_LINES-1:0]  hit_stat,
    output logic                  wr_slice_en,
    output logic                  wr_pend,
    output logic [NUM_LINES-1:0]  wr_mask,
    output logic [NUM_LINES-1:0]  wr_force,
    output logic                  wr_stat
);
    logic [OFF_W-1:0] offset;
    logic             region_ok;
    logic             wr_any;

    assign offset    = bus_addr[OFF_W-1:0];
    assign region_ok = (bus_addr[BUS_ADDR_W-1:OFF_W+2] == '0);
    assign op        = kind_to_op(acc_kind_e'(bus_addr[OFF_W+1:OFF_W]));
    assign wr_any    = bus_valid && bus_write && region_ok;

    assign hit_slice_en = region_ok && (offset == OFF_SLICE_EN);
    assign hit_pend     = region_ok && (offset == OFF_PEND);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line_dec
        localparam logic [OFF_W-1:0] MASK_AT  = line_reg_off(k, LINE_MASK_OFS);
        localparam logic [OFF_W-1:0] FORCE_AT = line_reg_off(k, LINE_FORCE_OFS);
        localparam logic [OFF_W-1:0] STAT_AT  = line_reg_off(k, LINE_STAT_OFS);
        assign hit_mask[k]  = region_ok && (offset == MASK_AT);
        assign hit_force[k] = region_ok && (offset == FORCE_AT);
        assign hit_stat[k]  = region_ok && (offset == STAT_AT);
        assign wr_mask[k]   = wr_any && hit_mask[k];
        assign wr_force[k]  = wr_any && hit_force[k];
    end

    assign wr_slice_en = wr_any && hit_slice_en;
    assign wr_pend     = wr_any && hit_pend;
    assign wr_stat     = wr_any && (|hit_stat);

endmodule

// File: rtl/pwm_ctl_bitreg.sv
module pwm_ctl_bitreg
    import pwm_ctl_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  wr_op_t       op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            if (op.set_bits)      q <= q | wdata;
            else if (op.clr_bits) q <= q & ~wdata;
            else                  q <= wdata;
        end
    end

    assert_plain_load_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !op.set_bits && !op.clr_bits) |=> (q == $past(wdata)));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (we && op.set_bits) |=> ((q & $past(wdata)) == $past(wdata)));

    assert_clr_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (we && op.clr_bits) |=> ((q & $past(wdata)) == '0));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/pwm_ctl_pending.sv
module pwm_ctl_pending
    import pwm_ctl_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wrap,
    input  logic         we,
    input  wr_op_t       op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_mask;

    // Set alias carries no meaning for a write-1-to-clear register
    assign clr_mask = (we && !op.set_bits) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_mask) | wrap;
    end

    assert_wrap_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |=> ((q & $past(wrap)) == $past(wrap)));

    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!we && wrap == '0) |=> $stable(q));

    assert_set_alias_void_R5: assert property (@(posedge clk) disable iff (rst)
        (we && op.set_bits && wrap == '0) |=> $stable(q));

endmodule

// File: rtl/pwm_ctl_irq_line.sv
module pwm_ctl_irq_line #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] force_bits,
    output logic [W-1:0] status,
    output logic         irq
);
    assign status = (pend & mask) | force_bits;
    assign irq    = |status;

    assert_force_raises_R8: assert property (@(posedge clk) disable iff (rst)
        (|force_bits) |-> irq);

    assert_quiet_when_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (mask == '0 && force_bits == '0) |-> !irq);

endmodule

// File: rtl/pwm_ctl_top.sv
module pwm_ctl_top
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_SLICES = 12,
    parameter int NUM_LINES  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [BUS_ADDR_W-1:0]  bus_addr,
    input  logic [BUS_DATA_W-1:0]  bus_wdata,
    output logic [BUS_DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SLICES-1:0]  wrap_pulse,
    output logic [NUM_SLICES-1:0]  slice_en,
    output logic [NUM_LINES-1:0]   irq
);
    wr_op_t                                op;
    logic                                  hit_slice_en, hit_pend, wr_slice_en, wr_pend, wr_stat;
    logic [NUM_LINES-1:0]                  hit_mask, hit_force, hit_stat, wr_mask, wr_force;
    logic [NUM_SLICES-1:0]                 wdata_s, pend_q;
    logic [NUM_LINES-1:0][NUM_SLICES-1:0]  mask_q, force_q, stat;
    logic                                  unused_upper;

    assign wdata_s      = bus_wdata[NUM_SLICES-1:0];
    assign unused_upper = ^bus_wdata[BUS_DATA_W-1:NUM_SLICES];

    pwm_ctl_decode #(.NUM_LINES(NUM_LINES)) u_dec (
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .op          (op),
        .hit_slice_en(hit_slice_en),
        .hit_pend    (hit_pend),
        .hit_mask    (hit_mask),
        .hit_force   (hit_force),
        .hit_stat    (hit_stat),
        .wr_slice_en (wr_slice_en),
        .wr_pend     (wr_pend),
        .wr_mask     (wr_mask),
        .wr_force    (wr_force),
        .wr_stat     (wr_stat)
    );

    pwm_ctl_bitreg #(.W(NUM_SLICES)) u_slice_en (
        .clk(clk), .rst(rst), .we(wr_slice_en), .op(op), .wdata(wdata_s), .q(slice_en)
    );

    pwm_ctl_pending #(.W(NUM_SLICES)) u_pend (
        .clk(clk), .rst(rst), .wrap(wrap_pulse), .we(wr_pend), .op(op),
        .wdata(wdata_s), .q(pend_q)
    );

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        pwm_ctl_bitreg #(.W(NUM_SLICES)) u_mask (
            .clk(clk), .rst(rst), .we(wr_mask[k]), .op(op), .wdata(wdata_s), .q(mask_q[k])
        );
        pwm_ctl_bitreg #(.W(NUM_SLICES)) u_force (
            .clk(clk), .rst(rst), .we(wr_force[k]), .op(op), .wdata(wdata_s), .q(force_q[k])
        );
        pwm_ctl_irq_line #(.W(NUM_SLICES)) u_irq (
            .clk(clk), .rst(rst), .pend(pend_q), .mask(mask_q[k]), .force_bits(force_q[k]),
            .status(stat[k]), .irq(irq[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_slice_en) bus_rdata[NUM_SLICES-1:0] = slice_en;
        if (hit_pend)     bus_rdata[NUM_SLICES-1:0] = pend_q;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (hit_mask[k])  bus_rdata[NUM_SLICES-1:0] = mask_q[k];
            if (hit_force[k]) bus_rdata[NUM_SLICES-1:0] = force_q[k];
            if (hit_stat[k])  bus_rdata[NUM_SLICES-1:0] = stat[k];
        end
    end

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_DATA_W-1:NUM_SLICES] == '0);

    assert_stat_write_void_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wrap_pulse == '0) |=> ($stable(irq) && $stable(slice_en)));

    assert_one_target_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_slice_en, hit_pend, hit_mask, hit_force, hit_stat}));

endmodule

// File: tb/tb_pwm_ctl_top.sv
module tb_pwm_ctl_top;
    localparam int NS = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [11:0] wrap_pulse = '0, slice_en;
    logic [1:0]  irq;

    int checks = 0, errors = 0;

    logic [11:0]      m_en, m_pend;
    logic [1:0][11:0] m_mask, m_force;

    always #10 clk = ~clk;

    pwm_ctl_top dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wrap_pulse(wrap_pulse), .slice_en(slice_en), .irq(irq)
    );

    function automatic logic [11:0] merge(logic [11:0] c, logic [11:0] w, logic [1:0] k);
        if (k == 2'b10) return c | w;
        if (k == 2'b11) return c & ~w;
        return w;
    endfunction

    function automatic logic [11:0] m_stat(int k);
        return (m_pend & m_mask[k]) | m_force[k];
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] off);
        if (off == 12'h0F0) return {20'h0, m_en};
        if (off == 12'h0F4) return {20'h0, m_pend};
        for (int k = 0; k < 2; k++) begin
            if (off == 12'h0F8 + 12'(12 * k)) return {20'h0, m_mask[k]};
            if (off == 12'h0FC + 12'(12 * k)) return {20'h0, m_force[k]};
            if (off == 12'h100 + 12'(12 * k)) return {20'h0, m_stat(k)};
        end
        return 32'h0;
    endfunction

    function automatic logic [1:0] exp_irq();
        return {|m_stat(1), |m_stat(0)};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic [1:0] kind, input logic [11:0] off,
                              input logic [31:0] d, input logic [11:0] wrap);
        logic [11:0] clr = '0;
        if (wr) begin
            if (off == 12'h0F0) m_en = merge(m_en, d[11:0], kind);
            if (off == 12'h0F4 && kind != 2'b10) clr = d[11:0];
            for (int k = 0; k < 2; k++) begin
                if (off == 12'h0F8 + 12'(12 * k)) m_mask[k]  = merge(m_mask[k], d[11:0], kind);
                if (off == 12'h0FC + 12'(12 * k)) m_force[k] = merge(m_force[k], d[11:0], kind);
            end
        end
        m_pend = (m_pend & ~clr) | wrap;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic op(input logic wr, input logic [1:0] kind, input logic [11:0] off,
                      input logic [31:0] d, input logic [11:0] wrap);
        bus_valid  = wr;
        bus_write  = wr;
        bus_addr   = {2'b00, kind, off};
        bus_wdata  = d;
        wrap_pulse = wrap;
        @(posedge clk);
        model_step(wr, kind, off, d, wrap);
        @(negedge clk);
        bus_valid  = 1'b0;
        bus_write  = 1'b0;
        wrap_pulse = '0;
    endtask

    task automatic rd(input logic [1:0] kind, input logic [11:0] off, input string tag);
        bus_addr = {2'b00, kind, off};
        #1;
        check(tag, bus_rdata, exp_read(off));
        #1;
    endtask

    task automatic chk_outs(input string tag);
        check({tag, " slice_en"}, {20'h0, slice_en}, {20'h0, m_en});
        check({tag, " irq"}, {30'h0, irq}, {30'h0, exp_irq()});
    endtask

    function automatic logic [11:0] pick_off(int unsigned i);
        case (i % 10)
            0: return 12'h0F0;  1: return 12'h0F4;  2: return 12'h0F8;  3: return 12'h0FC;
            4: return 12'h100;  5: return 12'h104;  6: return 12'h108;  7: return 12'h10C;
            8: return 12'h0F4;  default: return 12'h0E0;
        endcase
    endfunction

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        m_en = '0; m_pend = '0; m_mask = '0; m_force = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_outs("R1");
        for (int i = 0; i < 10; i++) rd(2'b00, pick_off(i), "R1 reset read");

        // R2 plain load, upper data bits ignored (R10)
        op(1, 2'b00, 12'h0F0, 32'hFFFF_FFA5, '0);
        chk_outs("R2");
        rd(2'b00, 12'h0F0, "R2 readback");
        rd(2'b00, 12'h0F0, "R10 upper zero");

        // R3 set / clear aliases
        op(1, 2'b10, 12'h0F0, 32'h0000_000A, '0);
        check("R3 set", {20'h0, slice_en}, 32'h0000_0FAF);
        op(1, 2'b11, 12'h0F0, 32'h0000_0F00, '0);
        check("R3 clr", {20'h0, slice_en}, 32'h0000_00AF);
        rd(2'b10, 12'h0F0, "R10 read via set alias");

        // R4 wrap latches and holds
        op(0, 2'b00, 12'h000, '0, 12'h003);
        rd(2'b00, 12'h0F4, "R4 latch");
        op(0, 2'b00, 12'h000, '0, '0);
        rd(2'b00, 12'h0F4, "R4 hold");

        // R5 clear semantics
        op(1, 2'b10, 12'h0F4, 32'h0000_0FFF, '0);
        check("R5 set alias void", {20'h0, dut.bus_rdata[11:0]} & 32'h0, 32'h0);
        rd(2'b00, 12'h0F4, "R5 set alias void");
        op(1, 2'b00, 12'h0F4, 32'h0000_0001, '0);
        rd(2'b00, 12'h0F4, "R5 plain w1c");
        op(1, 2'b11, 12'h0F4, 32'h0000_0002, '0);
        rd(2'b00, 12'h0F4, "R5 clr alias");

        // R6 wrap beats clear in the same cycle
        op(1, 2'b00, 12'h0F4, 32'h0000_0010, 12'h010);
        rd(2'b00, 12'h0F4, "R6 plain collision");
        op(1, 2'b11, 12'h0F4, 32'h0000_0010, 12'h010);
        rd(2'b00, 12'h0F4, "R6 alias collision");

        // R7 / R8 / R11 per-line masking
        op(1, 2'b00, 12'h0F8, 32'h0000_0010, '0);
        check("R8 irq0 up", {30'h0, irq}, 32'h1);
        check("R11 line1 untouched", {31'h0, irq[1]}, 32'h0);
        rd(2'b00, 12'h100, "R7 stat0");
        rd(2'b00, 12'h10C, "R11 stat1");
        op(1, 2'b10, 12'h108, 32'h0000_0800, '0);
        check("R8 force1", {30'h0, irq}, 32'h3);
        rd(2'b00, 12'h10C, "R7 stat1 force");
        op(1, 2'b00, 12'h0F4, 32'h0000_0FFF, '0);
        check("R8 irq0 down", {30'h0, irq}, 32'h2);

        // R9 status writes ignored
        for (int k = 0; k < 4; k++) begin
            op(1, 2'(k), 12'h100, 32'hFFFF_FFFF, '0);
            op(1, 2'(k), 12'h10C, 32'h0000_0000, '0);
        end
        chk_outs("R9");
        rd(2'b00, 12'h10C, "R9 stat1");
        rd(2'b00, 12'h100, "R9 stat0");

        // R10 unmapped offset and bad region
        op(1, 2'b00, 12'h0E0, 32'hFFFF_FFFF, '0);
        rd(2'b00, 12'h0E0, "R10 unmapped");
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 16'h40F0; bus_wdata = 32'hFFF;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        #1;
        check("R10 region read", bus_rdata, 32'h0);
        chk_outs("R10 region write");

        // Random phase
        for (int n = 0; n < 800; n++) begin
            logic [1:0]  kind;
            logic [11:0] off, wrap;
            logic        wr;
            kind = 2'($urandom_range(0, 3));
            off  = pick_off($urandom);
            wr   = ($urandom_range(0, 9) != 0);
            wrap = ($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'h0;
            op(wr, kind, off, $urandom, wrap);
            chk_outs("R8 random");
            rd(2'($urandom_range(0, 3)), pick_off($urandom), "R7 random read");
            rd(2'b00, 12'h0F4, "R6 random pending");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule